// File: doc/BRIEF.md
# DMA Single/Burst Request Sequencer

This block serves a small group of DMA channels. Each channel presents two request lines from its peripheral. One line asks for a single item to be moved. The other asks for a group of items. Software loads a descriptor for each channel through a write port. The descriptor holds a source pointer, a destination pointer, an item count, an arbitration-size code and a burst-only bit. Loading a non-zero count enables the channel.

When no transfer is in progress, the sequencer grants the lowest-numbered eligible channel. It then works out how many items the grant covers. A single request covers one item. A burst request covers the smaller of the arbitration size and the items still remaining. The block then raises an item strobe towards the data path, together with the channel's pointers, and waits on a ready handshake for each item. Once started, a burst is never broken off. When the remaining count reaches zero, the channel raises a one-cycle done pulse and disables itself.

Fetching the control table, pointer arithmetic and the bus fabric belong to the surrounding logic.

Top module: `dma_req_sequencer`

## Requirements
- R1: A granted single request moves exactly one item. `xfer_valid` then drops for at least one cycle before any new grant.
- R2: A granted burst request moves min(arbitration size, remaining count) items back to back on the same channel.
- R3: When a channel's single and burst lines are both high at the grant, the grant is treated as a burst.
- R4: A burst in progress is never interrupted, including by a burst request on a higher-priority channel.
- R5: Priority is fixed, with channel 0 the highest. A new grant is made only when no item group is in progress.
- R6: With the burst-only bit set, the channel's single line is ignored: no item moves and the channel stays enabled with its count unchanged. Its burst line is still served.
- R7: In the cycle after the last remaining item is accepted, that channel's `done` bit is high for exactly one cycle and its `ch_en` bit goes low. Later requests on the channel move nothing until a new descriptor is written.
- R8: An item is accepted at a rising edge where `xfer_valid` and `xfer_ready` are both high. While `xfer_ready` is low, `xfer_valid` and `xfer_ch` hold. The remaining count drops by one for each accepted item.
- R9: The 4-bit arbitration code v selects 2^v items for v from 0 to 10. Codes 11 to 15 select 1024 items.
- R10: A descriptor write (`cfg_we` high at an edge) loads all fields of channel `cfg_ch`. It sets `ch_en` if `cfg_count` is non-zero and clears it if `cfg_count` is zero.
- R11: A descriptor write addressed to the channel whose transfer is in progress is ignored.
- R12: After reset, `xfer_valid` is low, `done` is all zero and every channel is disabled.
- R13: While `xfer_valid` is high, `xfer_src` and `xfer_dst` show the pointers loaded for channel `xfer_ch`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| single_req | input | NUM_CH | Per-channel single-item request level |
| burst_req | input | NUM_CH | Per-channel burst request level |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_ch | input | CH_W | Channel addressed by the write |
| cfg_src | input | ADDR_W | Source pointer to load |
| cfg_dst | input | ADDR_W | Destination pointer to load |
| cfg_count | input | CNT_W | Item count to load; zero disables the channel |
| cfg_arb | input | ASZ_W | Arbitration-size code (log2 of items) |
| cfg_burst_only | input | 1 | Ignore single requests on this channel |
| xfer_valid | output | 1 | An item transfer is presented |
| xfer_ready | input | 1 | Data path accepts the presented item |
| xfer_ch | output | CH_W | Channel of the presented item |
| xfer_src | output | ADDR_W | Source pointer of that channel |
| xfer_dst | output | ADDR_W | Destination pointer of that channel |
| done | output | NUM_CH | One-cycle pulse when a channel's count reaches zero |
| ch_en | output | NUM_CH | Per-channel enabled state |

## Verification
The bench raises a higher-priority burst in the middle of a lower-priority burst. A sequencer that re-arbitrates at every item would interleave the two channels in the item log. It gives a burst a count smaller than the arbitration size, and uses codes 0 and 15. A wrong minimum or a wrong clamp would move too many or too few items and miss the done pulse. Single requests are sent both on a burst-only channel and together with a burst line. A leaky mask would move an item there, and a wrong precedence rule would move one item where four were due. Descriptor writes are aimed at a channel stalled mid-burst, and at channels that have finished. An unprotected write would reload the count and leave the channel enabled. A done channel that still answered requests would add items to the log.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

   // engine phase
   typedef enum logic {
      ENG_IDLE = 1'b0,
      ENG_MOVE = 1'b1
   } eng_state_t;

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
   parameter int NUM_CH = 4,
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 32,
   parameter int ASZ_W  = 4,
   parameter int CH_W   = 2
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             cfg_we,
   input  logic [CH_W-1:0]                  cfg_ch,
   input  logic [ADDR_W-1:0]                cfg_src,
   input  logic [ADDR_W-1:0]                cfg_dst,
   input  logic [CNT_W-1:0]                 cfg_count,
   input  logic [ASZ_W-1:0]                 cfg_arb,
   input  logic                             cfg_burst_only,
   input  logic                             busy,
   input  logic [CH_W-1:0]                  act_ch,
   input  logic                             item_acc,
   output logic [NUM_CH-1:0]                en,
   output logic [NUM_CH-1:0]                bonly,
   output logic [NUM_CH-1:0][CNT_W-1:0]     rem,
   output logic [NUM_CH-1:0][ASZ_W-1:0]     arb,
   output logic [NUM_CH-1:0][ADDR_W-1:0]    src,
   output logic [NUM_CH-1:0][ADDR_W-1:0]    dst,
   output logic [NUM_CH-1:0]                done
);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic is_act;
      logic load;
      logic hit;

      assign is_act = (act_ch == CH_W'(i));
      // a write never lands on the channel being served
      assign load   = cfg_we && (cfg_ch == CH_W'(i)) && !(busy && is_act);
      assign hit    = item_acc && is_act;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en[i]    <= 1'b0;
            bonly[i] <= 1'b0;
            rem[i]   <= '0;
            arb[i]   <= '0;
            src[i]   <= '0;
            dst[i]   <= '0;
            done[i]  <= 1'b0;
         end else begin
            done[i] <= hit && (rem[i] == CNT_W'(1));
            if (load) begin
               rem[i]   <= cfg_count;
               en[i]    <= (cfg_count != '0);
               arb[i]   <= cfg_arb;
               bonly[i] <= cfg_burst_only;
               src[i]   <= cfg_src;
               dst[i]   <= cfg_dst;
            end else if (hit) begin
               rem[i] <= rem[i] - CNT_W'(1);
               if (rem[i] == CNT_W'(1)) begin
                  en[i] <= 1'b0;
               end
            end
         end
      end
   end

endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
   parameter int NUM_CH    = 4,
   parameter int CH_W      = 2,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic [NUM_CH-1:0] req,
   output logic              any,
   output logic [CH_W-1:0]   idx
);

   assign any = |req;

   if (LOW_FIRST) begin : g_low
      // scan downwards so the lowest index is written last
      always_comb begin
         idx = '0;
         for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (req[i]) idx = CH_W'(i);
         end
      end
   end else begin : g_high
      always_comb begin
         idx = '0;
         for (int i = 0; i < NUM_CH; i++) begin
            if (req[i]) idx = CH_W'(i);
         end
      end
   end

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
   import dma_seq_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int ASZ_W   = 4,
   parameter int CH_W    = 2,
   parameter int MAX_LOG = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             grant_any,
   input  logic [CH_W-1:0]  grant_ch,
   input  logic             grant_burst,
   input  logic [CNT_W-1:0] grant_rem,
   input  logic [ASZ_W-1:0] grant_arb,
   input  logic             xfer_ready,
   output logic             busy,
   output logic [CH_W-1:0]  act_ch,
   output logic             item_acc,
   output logic             last
);

   localparam int W = (CNT_W > MAX_LOG + 1) ? CNT_W : MAX_LOG + 1;

   eng_state_t       state_q;
   logic [CH_W-1:0]  ch_q;
   logic [W-1:0]     left_q;
   logic [ASZ_W-1:0] lg;
   logic [W-1:0]     bsz;
   logic [W-1:0]     rem_w;
   logic [W-1:0]     items;

   always_comb begin
      lg    = (grant_arb > ASZ_W'(MAX_LOG)) ? ASZ_W'(MAX_LOG) : grant_arb;
      bsz   = W'(1) << lg;
      rem_w = W'(grant_rem);
      if (grant_burst) begin
         items = (bsz < rem_w) ? bsz : rem_w;
      end else begin
         items = W'(1);
      end
   end

   assign busy     = (state_q == ENG_MOVE);
   assign act_ch   = ch_q;
   assign item_acc = busy && xfer_ready;
   assign last     = (left_q == W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ENG_IDLE;
         ch_q    <= '0;
         left_q  <= '0;
      end else begin
         case (state_q)
            ENG_IDLE: begin
               if (grant_any) begin
                  state_q <= ENG_MOVE;
                  ch_q    <= grant_ch;
                  left_q  <= items;
               end
            end
            default: begin
               if (item_acc) begin
                  left_q <= left_q - W'(1);
                  if (last) begin
                     state_q <= ENG_IDLE;
                  end
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/dma_req_sequencer.sv
module dma_req_sequencer #(
   parameter int NUM_CH    = 4,
   parameter int CNT_W     = 16,
   parameter int ADDR_W    = 32,
   parameter int ASZ_W     = 4,
   parameter int MAX_LOG   = 10,
   parameter bit LOW_FIRST = 1'b1,
   localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_CH-1:0]    single_req,
   input  logic [NUM_CH-1:0]    burst_req,
   input  logic                 cfg_we,
   input  logic [CH_W-1:0]      cfg_ch,
   input  logic [ADDR_W-1:0]    cfg_src,
   input  logic [ADDR_W-1:0]    cfg_dst,
   input  logic [CNT_W-1:0]     cfg_count,
   input  logic [ASZ_W-1:0]     cfg_arb,
   input  logic                 cfg_burst_only,
   output logic                 xfer_valid,
   input  logic                 xfer_ready,
   output logic [CH_W-1:0]      xfer_ch,
   output logic [ADDR_W-1:0]    xfer_src,
   output logic [ADDR_W-1:0]    xfer_dst,
   output logic [NUM_CH-1:0]    done,
   output logic [NUM_CH-1:0]    ch_en
);

   if (NUM_CH < 2) begin : g_bad_ch
      $error("NUM_CH must be at least 2");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be positive");
   end
   if (MAX_LOG >= (1 << ASZ_W)) begin : g_bad_log
      $error("MAX_LOG must fit in the arbitration code");
   end

   logic [NUM_CH-1:0]             bonly;
   logic [NUM_CH-1:0][CNT_W-1:0]  rem;
   logic [NUM_CH-1:0][ASZ_W-1:0]  arb;
   logic [NUM_CH-1:0][ADDR_W-1:0] src;
   logic [NUM_CH-1:0][ADDR_W-1:0] dst;
   logic [NUM_CH-1:0]             elig;
   logic                          grant_any;
   logic [CH_W-1:0]               grant_ch;
   logic                          busy;
   logic [CH_W-1:0]               act_ch;
   logic                          item_acc;
   logic                          eng_last;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_elig
      assign elig[i] = ch_en[i] && (burst_req[i] || (single_req[i] && !bonly[i]));
   end

   dma_chan_regs #(
      .NUM_CH (NUM_CH),
      .CNT_W  (CNT_W),
      .ADDR_W (ADDR_W),
      .ASZ_W  (ASZ_W),
      .CH_W   (CH_W)
   ) u_regs (
      .clk            (clk),
      .rst_n          (rst_n),
      .cfg_we         (cfg_we),
      .cfg_ch         (cfg_ch),
      .cfg_src        (cfg_src),
      .cfg_dst        (cfg_dst),
      .cfg_count      (cfg_count),
      .cfg_arb        (cfg_arb),
      .cfg_burst_only (cfg_burst_only),
      .busy           (busy),
      .act_ch         (act_ch),
      .item_acc       (item_acc),
      .en             (ch_en),
      .bonly          (bonly),
      .rem            (rem),
      .arb            (arb),
      .src            (src),
      .dst            (dst),
      .done           (done)
   );

   dma_prio_pick #(
      .NUM_CH    (NUM_CH),
      .CH_W      (CH_W),
      .LOW_FIRST (LOW_FIRST)
   ) u_pick (
      .req (elig),
      .any (grant_any),
      .idx (grant_ch)
   );

   dma_xfer_engine #(
      .CNT_W   (CNT_W),
      .ASZ_W   (ASZ_W),
      .CH_W    (CH_W),
      .MAX_LOG (MAX_LOG)
   ) u_eng (
      .clk         (clk),
      .rst_n       (rst_n),
      .grant_any   (grant_any),
      .grant_ch    (grant_ch),
      .grant_burst (burst_req[grant_ch]),
      .grant_rem   (rem[grant_ch]),
      .grant_arb   (arb[grant_ch]),
      .xfer_ready  (xfer_ready),
      .busy        (busy),
      .act_ch      (act_ch),
      .item_acc    (item_acc),
      .last        (eng_last)
   );

   assign xfer_valid = busy;
   assign xfer_ch    = act_ch;
   assign xfer_src   = src[act_ch];
   assign xfer_dst   = dst[act_ch];

endmodule

// File: rtl/dma_req_sequencer_chk.sv
module dma_req_sequencer_chk #(
   parameter int NUM_CH = 4,
   parameter int CH_W   = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              xfer_valid,
   input logic              xfer_ready,
   input logic [CH_W-1:0]   xfer_ch,
   input logic              eng_last,
   input logic [NUM_CH-1:0] done,
   input logic [NUM_CH-1:0] ch_en
);

   assert_done_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(done));

   assert_done_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done & $past(done)) == '0);

   assert_done_disables_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done & ch_en) == '0);

   assert_active_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid |-> ch_en[xfer_ch]);

   assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_ch)));

   assert_burst_atomic_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid && xfer_ready && !eng_last) |=> (xfer_valid && $stable(xfer_ch)));

   assert_group_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid && xfer_ready && eng_last) |=> !xfer_valid);

endmodule

bind dma_req_sequencer dma_req_sequencer_chk #(
   .NUM_CH (NUM_CH),
   .CH_W   (CH_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .xfer_valid (xfer_valid),
   .xfer_ready (xfer_ready),
   .xfer_ch    (xfer_ch),
   .eng_last   (eng_last),
   .done       (done),
   .ch_en      (ch_en)
);

// File: tb/dma_req_sequencer_tb.sv
module dma_req_sequencer_tb;

   localparam int NCH = 4;
   localparam int CW  = 2;
   localparam int NW  = 16;
   localparam int AW  = 32;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] single_req = '0;
   logic [NCH-1:0] burst_req = '0;
   logic           cfg_we = 1'b0;
   logic [CW-1:0]  cfg_ch = '0;
   logic [AW-1:0]  cfg_src = '0;
   logic [AW-1:0]  cfg_dst = '0;
   logic [NW-1:0]  cfg_count = '0;
   logic [3:0]     cfg_arb = '0;
   logic           cfg_burst_only = 1'b0;
   logic           xfer_ready = 1'b1;
   logic           xfer_valid;
   logic [CW-1:0]  xfer_ch;
   logic [AW-1:0]  xfer_src;
   logic [AW-1:0]  xfer_dst;
   logic [NCH-1:0] done;
   logic [NCH-1:0] ch_en;

   always #2 clk = ~clk;   // 250 MHz

   dma_req_sequencer u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .single_req     (single_req),
      .burst_req      (burst_req),
      .cfg_we         (cfg_we),
      .cfg_ch         (cfg_ch),
      .cfg_src        (cfg_src),
      .cfg_dst        (cfg_dst),
      .cfg_count      (cfg_count),
      .cfg_arb        (cfg_arb),
      .cfg_burst_only (cfg_burst_only),
      .xfer_valid     (xfer_valid),
      .xfer_ready     (xfer_ready),
      .xfer_ch        (xfer_ch),
      .xfer_src       (xfer_src),
      .xfer_dst       (xfer_dst),
      .done           (done),
      .ch_en          (ch_en)
   );

   int n_chk  = 0;
   int n_fail = 0;
   int beats [NCH];
   int dones [NCH];
   int log_q [4096];
   int log_n = 0;
   bit mon_on = 1'b0;

   // monitor: sampled mid-cycle, values hold until the next rising edge
   always @(negedge clk) begin
      #1;
      if (mon_on) begin
         if (xfer_valid && xfer_ready) begin
            beats[xfer_ch] = beats[xfer_ch] + 1;
            if (log_n < 4096) log_q[log_n] = int'(xfer_ch);
            log_n = log_n + 1;
         end
         for (int c = 0; c < NCH; c++) begin
            if (done[c]) dones[c] = dones[c] + 1;
         end
      end
   end

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
   endtask

   task automatic wr(input int ch, input int src, input int dst, input int cnt,
                     input int arb, input bit bo);
      @(negedge clk);
      cfg_we         = 1'b1;
      cfg_ch         = CW'(ch);
      cfg_src        = AW'(src);
      cfg_dst        = AW'(dst);
      cfg_count      = NW'(cnt);
      cfg_arb        = 4'(arb);
      cfg_burst_only = bo;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic pulse(input logic [NCH-1:0] s, input logic [NCH-1:0] b);
      @(negedge clk);
      single_req = s;
      burst_req  = b;
      @(negedge clk);
      single_req = '0;
      burst_req  = '0;
   endtask

   task automatic wait_idle();
      int quiet = 0;
      for (int k = 0; k < 3000 && quiet < 4; k++) begin
         @(negedge clk);
         #2;
         if (!xfer_valid) quiet++;
         else quiet = 0;
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      #2;
      chk("R12", "xfer_valid after reset", xfer_valid, 0);
      chk("R12", "done after reset", done, 0);
      chk("R12", "ch_en after reset", ch_en, 0);
   endtask

   task automatic t_single();
      int b0;
      wr(1, 'h100, 'h200, 10, 4, 0);
      #2;
      chk("R10", "ch_en after load", ch_en[1], 1);
      b0 = beats[1];
      pulse(4'b0010, 4'b0000);
      wait_idle();
      chk("R1", "single request items", beats[1] - b0, 1);
      chk("R1", "channel still enabled", ch_en[1], 1);
   endtask

   task automatic t_burst_arb();
      int b0;
      wr(1, 'h100, 'h200, 40, 3, 0);
      b0 = beats[1];
      pulse(4'b0000, 4'b0010);
      wait_idle();
      chk("R2", "burst limited by arbitration size 8", beats[1] - b0, 8);
      chk("R2", "enabled with items left", ch_en[1], 1);
   endtask

   task automatic t_burst_rem();
      int b0, d0;
      wr(1, 'h100, 'h200, 5, 4, 0);
      b0 = beats[1];
      d0 = dones[1];
      pulse(4'b0000, 4'b0010);
      wait_idle();
      chk("R2", "burst limited by remaining 5", beats[1] - b0, 5);
      chk("R7", "done pulses once", dones[1] - d0, 1);
      chk("R7", "disabled at zero", ch_en[1], 0);
   endtask

   task automatic t_both();
      int b0;
      wr(2, 'h300, 'h400, 20, 2, 0);
      b0 = beats[2];
      pulse(4'b0100, 4'b0100);
      wait_idle();
      chk("R3", "burst wins over single", beats[2] - b0, 4);
   endtask

   task automatic t_mask();
      int b0;
      wr(3, 'h500, 'h600, 20, 2, 1);
      b0 = beats[3];
      pulse(4'b1000, 4'b0000);
      wait_idle();
      chk("R6", "single ignored on burst-only channel", beats[3] - b0, 0);
      chk("R6", "burst-only channel stays enabled", ch_en[3], 1);
      pulse(4'b0000, 4'b1000);
      wait_idle();
      chk("R6", "burst still served, count intact", beats[3] - b0, 4);
      chk("R6", "still enabled after 4 of 20", ch_en[3], 1);
   endtask

   task automatic t_prio();
      int s;
      wr(0, 'h10, 'h20, 9, 0, 0);
      wr(3, 'h30, 'h40, 9, 0, 0);
      s = log_n;
      pulse(4'b1001, 4'b0000);
      wait_idle();
      chk("R5", "items moved", log_n - s, 1);
      chk("R5", "lowest channel wins", log_q[s], 0);
   endtask

   task automatic t_nopreempt();
      int s, bad, d0;
      wr(2, 'h300, 'h400, 30, 3, 0);
      wr(0, 'h10, 'h20, 4, 3, 0);
      s  = log_n;
      d0 = dones[0];
      pulse(4'b0000, 4'b0100);
      @(negedge clk);
      burst_req = 4'b0001;
      wait_idle();
      burst_req = '0;
      chk("R4", "total items", log_n - s, 12);
      bad = 0;
      for (int k = 0; k < 12; k++) begin
         if (log_q[s + k] != ((k < 8) ? 2 : 0)) bad++;
      end
      chk("R4", "item order mismatches", bad, 0);
      chk("R7", "ch0 done under held request", dones[0] - d0, 1);
   endtask

   task automatic t_stall();
      int b0, d0;
      wr(1, 'h1234, 'h5678, 6, 4, 0);
      b0 = beats[1];
      d0 = dones[1];
      @(negedge clk);
      xfer_ready = 1'b0;
      pulse(4'b0000, 4'b0010);
      repeat (5) @(negedge clk);
      #2;
      chk("R8", "valid held while not ready", xfer_valid, 1);
      chk("R8", "channel held while not ready", xfer_ch, 1);
      chk("R8", "no items while not ready", beats[1] - b0, 0);
      chk("R13", "source pointer", xfer_src, 'h1234);
      chk("R13", "destination pointer", xfer_dst, 'h5678);
      @(negedge clk);
      xfer_ready = 1'b1;
      wait_idle();
      chk("R8", "items after release", beats[1] - b0, 6);
      chk("R8", "done after release", dones[1] - d0, 1);
   endtask

   task automatic t_done();
      int b0, d0;
      wr(0, 'h10, 'h20, 2, 0, 0);
      b0 = beats[0];
      d0 = dones[0];
      pulse(4'b0001, 4'b0000);
      wait_idle();
      chk("R7", "no done before zero", dones[0] - d0, 0);
      pulse(4'b0001, 4'b0000);
      wait_idle();
      chk("R7", "done once at zero", dones[0] - d0, 1);
      chk("R7", "disabled", ch_en[0], 0);
      pulse(4'b0001, 4'b0001);
      wait_idle();
      chk("R7", "requests ignored after done", beats[0] - b0, 2);
   endtask

   task automatic t_clamp();
      int b0, d0;
      wr(1, 'h100, 'h200, 1500, 15, 0);
      b0 = beats[1];
      d0 = dones[1];
      pulse(4'b0000, 4'b0010);
      wait_idle();
      chk("R9", "code 15 clamps to 1024", beats[1] - b0, 1024);
      pulse(4'b0000, 4'b0010);
      wait_idle();
      chk("R9", "remaining 476 moved", beats[1] - b0, 1500);
      chk("R9", "done after 1500", dones[1] - d0, 1);
      wr(2, 'h300, 'h400, 5, 0, 0);
      b0 = beats[2];
      pulse(4'b0000, 4'b0100);
      wait_idle();
      chk("R9", "code 0 is one item", beats[2] - b0, 1);
   endtask

   task automatic t_zero();
      int b0;
      wr(3, 'h500, 'h600, 5, 2, 0);
      #2;
      chk("R10", "enabled by non-zero count", ch_en[3], 1);
      wr(3, 'h500, 'h600, 0, 2, 0);
      #2;
      chk("R10", "disabled by zero count", ch_en[3], 0);
      b0 = beats[3];
      pulse(4'b0000, 4'b1000);
      wait_idle();
      chk("R10", "zero-count channel moves nothing", beats[3] - b0, 0);
   endtask

   task automatic t_wprot();
      int b0, d0;
      wr(2, 'h300, 'h400, 6, 3, 0);
      b0 = beats[2];
      d0 = dones[2];
      @(negedge clk);
      xfer_ready = 1'b0;
      pulse(4'b0000, 4'b0100);
      wr(2, 'h900, 'h900, 100, 3, 0);
      #2;
      chk("R11", "pointer unchanged by blocked write", xfer_src, 'h300);
      @(negedge clk);
      xfer_ready = 1'b1;
      wait_idle();
      chk("R11", "items from original count", beats[2] - b0, 6);
      chk("R11", "done from original count", dones[2] - d0, 1);
      chk("R11", "disabled at original zero", ch_en[2], 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      summary();
      $finish;
   end

   initial begin
      for (int c = 0; c < NCH; c++) begin
         beats[c] = 0;
         dones[c] = 0;
      end
      repeat (5) @(negedge clk);
      rst_n  = 1'b1;
      mon_on = 1'b1;
      t_reset();
      t_single();
      t_burst_arb();
      t_burst_rem();
      t_both();
      t_mask();
      t_prio();
      t_nopreempt();
      t_stall();
      t_done();
      t_clamp();
      t_zero();
      t_wprot();
      summary();
      $finish;
   end

endmodule